// File: doc/BRIEF.md
# Masked Fault Latch and Alert Controller

This block holds the fault bookkeeping of a supply-protection controller. A status register shows the live fault conditions. A fault register latches each condition as a sticky bit. An alert-mask register picks which fault bits may pull the shared alert line low, and a control register holds software switches, one of which acts as an on/off request. Bus activity reaches the block as single-cycle strobes: register writes, "alert response address served" and "this device was addressed". The serial engine and bus arbitration live elsewhere.

The alert follows the usual shared-alert-line rules. It is driven low once for each new masked fault occurrence. A bus response releases it. A fault that keeps recurring does not drive it low again until its bit has been cleared. A sticky bit cannot be cleared while its live condition persists. Several clear-all events exist, and each has its own effect.

Bit map (fault and status): 0 overvoltage, 1 undervoltage, 2 overcurrent, 3 power bad, 4 enable changed, 5 switch short, 6 general-purpose input, 7 external fault.

Top module: `fault_alert_regs`

## Requirements
- R1: After reset, status, fault, mask and ctrl read 0 and alert_n reads 1.
- R2: On each edge, status captures its inputs. Bits 3..0 take cond_live[3:0]. Bit 5 is 1 when sense_code >= SHORT_CODE (default 8) while gate_on is 0. Bit 6 takes gp_in_high. Bits 4 and 7 always read 0.
- R3: Each of these sets its fault bit at the next edge: a cond_set[i] pulse (bits 3..0), a short detection (bit 5), gp_in_high (bit 6) and ext_fault_low (bit 7). A set bit stays set when its source goes away.
- R4: A fault_wr clears, at the next edge, every fault bit written as 0 and keeps every bit written as 1. A bit whose status bit was 1 in that cycle keeps its value.
- R5: A set and any clear that reach the same fault bit in the same cycle leave the bit at 1.
- R6: Three events clear the whole fault register at the next edge: a falling edge of on_pin, a ctrl write that takes ctrl bit 3 from 1 to 0, and uvlo high. Bits whose status is 1 are kept.
- R7: A falling edge of en_pin clears every fault bit except bit 4 and sets bit 4.
- R8: mask_wr loads mask from mask_wdata. Mask bit 6 always reads 0, so fault bit 6 never drives the alert.
- R9: alert_n goes low one cycle after a fault bit changes from 0 to 1 while its mask bit is 1. Unmasked bits never drive it low.
- R10: An ara_served or dev_addressed strobe drives alert_n high at the next edge, unless a new masked fault rises in that same cycle.
- R11: After a release, alert_n stays high while a set fault bit keeps being set. It goes low again only after that bit is cleared and set once more, or after a different masked bit sets.
- R12: ctrl_wr loads ctrl from ctrl_wdata, and ctrl reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_live | input | 4 | Live conditions for bits 3..0 |
| cond_set | input | 4 | Set pulses for fault bits 3..0 |
| sense_code | input | SENSE_W | Current-sense reading from the converter |
| gate_on | input | 1 | High while the pass switch is driven on |
| gp_in_high | input | 1 | General-purpose input above its threshold |
| ext_fault_low | input | 1 | External fault input below its threshold |
| on_pin | input | 1 | On request level |
| en_pin | input | 1 | Enable level |
| uvlo | input | 1 | Internal supply lockout flag |
| fault_wr | input | 1 | Fault register write strobe |
| fault_wdata | input | 8 | Fault write data, 0 clears |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ara_served | input | 1 | Alert response address served by this device |
| dev_addressed | input | 1 | Device addressed by the bus master |
| status | output | 8 | Status register |
| fault | output | 8 | Sticky fault register |
| mask | output | 8 | Alert mask register |
| ctrl | output | 8 | Control register |
| alert_n | output | 1 | Alert line, low = asserted |

## Verification
A wrong previous-value copy of the fault register appears on alert_n within two cycles of a set pulse. It shows either as a missing low or as a second low for a fault that is still present. A stale edge-detect flop on on_pin or en_pin shows at the fault port at the edge after the pin moves: a clear that should not happen, a missed clear, or bit 4 in the wrong state. Because the bench model is compared with every port on every clock, a corrupted status bit shows within one edge. It appears as a sticky bit that refuses to clear, or as a bit that clears too early.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
  localparam int REG_W  = 8;
  localparam int N_COND = 4;
  localparam int B_EN   = 4;
  localparam int B_SHRT = 5;
  localparam int B_GPI  = 6;
  localparam int B_EXT  = 7;

  // bits that can never reach the alert line
  localparam logic [REG_W-1:0] NO_ALERT = REG_W'(1) << B_GPI;

  // fault register after all clear sources, before sets are merged in
  function automatic logic [REG_W-1:0] apply_clears(
    input logic [REG_W-1:0] cur,
    input logic             wr,
    input logic [REG_W-1:0] wdata,
    input logic             clr_all,
    input logic             en_fall,
    input logic [REG_W-1:0] live
  );
    logic [REG_W-1:0] keep;
    keep = cur;
    if (wr)      keep = keep & wdata;
    if (clr_all) keep = '0;
    if (en_fall) keep = keep & (REG_W'(1) << B_EN);
    return keep | (cur & live);
  endfunction
endpackage

// File: rtl/fa_status_reg.sv
module fa_status_reg
  import fault_alert_pkg::*;
#(
  parameter int SENSE_W    = 12,
  parameter int SHORT_CODE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_COND-1:0]  cond_live,
  input  logic [SENSE_W-1:0] sense_code,
  input  logic               gate_on,
  input  logic               gp_in_high,
  output logic               short_hit,
  output logic [REG_W-1:0]   status_q
);
  localparam logic [SENSE_W-1:0] LIMIT = SENSE_W'(SHORT_CODE);

  function automatic logic short_detect(input logic [SENSE_W-1:0] code,
                                        input logic gate);
    return (code >= LIMIT) && !gate;
  endfunction

  logic [REG_W-1:0] status_d;

  assign short_hit = short_detect(sense_code, gate_on);

  always_comb begin
    status_d                 = '0;
    status_d[N_COND-1:0]     = cond_live;
    status_d[B_SHRT]         = short_hit;
    status_d[B_GPI]          = gp_in_high;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/fa_fault_bank.sv
module fa_fault_bank
  import fault_alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             clr_all,
  input  logic             en_fall,
  input  logic [REG_W-1:0] live,
  output logic [REG_W-1:0] fault_q
);
  logic [REG_W-1:0] kept;
  logic [REG_W-1:0] fault_d;

  assign kept    = apply_clears(fault_q, wr, wdata, clr_all, en_fall, live);
  assign fault_d = kept | set_vec;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= fault_d[b];
    end
    assign fault_q[b] = bit_q;
  end
endmodule

// File: rtl/fa_alert_ctl.sv
module fa_alert_ctl
  import fault_alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] fault_q,
  input  logic [REG_W-1:0] mask_q,
  input  logic             release_evt,
  output logic             new_masked,
  output logic             alert_n
);
  logic [REG_W-1:0] prev_q;
  logic             pend_q;

  assign new_masked = |(fault_q & ~prev_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= fault_q;
      if (new_masked)       pend_q <= 1'b1;
      else if (release_evt) pend_q <= 1'b0;
    end
  end

  assign alert_n = ~pend_q;
endmodule

// File: rtl/fault_alert_regs.sv
module fault_alert_regs
  import fault_alert_pkg::*;
#(
  parameter int SENSE_W    = 12,
  parameter int SHORT_CODE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         cond_live,
  input  logic [3:0]         cond_set,
  input  logic [SENSE_W-1:0] sense_code,
  input  logic               gate_on,
  input  logic               gp_in_high,
  input  logic               ext_fault_low,
  input  logic               on_pin,
  input  logic               en_pin,
  input  logic               uvlo,
  input  logic               fault_wr,
  input  logic [7:0]         fault_wdata,
  input  logic               mask_wr,
  input  logic [7:0]         mask_wdata,
  input  logic               ctrl_wr,
  input  logic [7:0]         ctrl_wdata,
  input  logic               ara_served,
  input  logic               dev_addressed,
  output logic [7:0]         status,
  output logic [7:0]         fault,
  output logic [7:0]         mask,
  output logic [7:0]         ctrl,
  output logic               alert_n
);
  localparam int CTRL_OFF_BIT = 3;

  logic             on_prev_q, en_prev_q;
  logic [REG_W-1:0] mask_q, ctrl_q;
  logic             short_hit;
  logic             on_fall, en_fall, ctrl_fall, clr_all;
  logic [REG_W-1:0] set_vec;
  logic             new_masked;

  fa_status_reg #(.SENSE_W(SENSE_W), .SHORT_CODE(SHORT_CODE)) u_status (
    .clk(clk), .rst_n(rst_n), .cond_live(cond_live), .sense_code(sense_code),
    .gate_on(gate_on), .gp_in_high(gp_in_high), .short_hit(short_hit),
    .status_q(status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_prev_q <= 1'b0;
      en_prev_q <= 1'b0;
      mask_q    <= '0;
      ctrl_q    <= '0;
    end else begin
      on_prev_q <= on_pin;
      en_prev_q <= en_pin;
      if (mask_wr) mask_q <= mask_wdata & ~NO_ALERT;
      if (ctrl_wr) ctrl_q <= ctrl_wdata;
    end
  end

  assign on_fall   = on_prev_q & ~on_pin;
  assign en_fall   = en_prev_q & ~en_pin;
  assign ctrl_fall = ctrl_wr & ctrl_q[CTRL_OFF_BIT] & ~ctrl_wdata[CTRL_OFF_BIT];
  assign clr_all   = on_fall | ctrl_fall | uvlo;

  always_comb begin
    set_vec               = '0;
    set_vec[N_COND-1:0]   = cond_set;
    set_vec[B_EN]         = en_fall;
    set_vec[B_SHRT]       = short_hit;
    set_vec[B_GPI]        = gp_in_high;
    set_vec[B_EXT]        = ext_fault_low;
  end

  fa_fault_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr(fault_wr),
    .wdata(fault_wdata), .clr_all(clr_all), .en_fall(en_fall),
    .live(status), .fault_q(fault)
  );

  fa_alert_ctl u_alert (
    .clk(clk), .rst_n(rst_n), .fault_q(fault), .mask_q(mask_q),
    .release_evt(ara_served | dev_addressed), .new_masked(new_masked),
    .alert_n(alert_n)
  );

  assign mask = mask_q;
  assign ctrl = ctrl_q;
endmodule

// File: rtl/fault_alert_regs_chk.sv
module fault_alert_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alert_n,
  input logic       ara_served,
  input logic       dev_addressed,
  input logic       new_masked,
  input logic [7:0] mask,
  input logic [7:0] fault,
  input logic [7:0] status,
  input logic [7:0] set_vec,
  input logic       clr_all,
  input logic       en_fall
);
  a_r9_alert_needs_masked_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_n) |-> $past(new_masked));

  a_r10_release_on_bus_event: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_served || dev_addressed) && !new_masked |=> alert_n);

  a_r11_alert_held_until_release: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n && !ara_served && !dev_addressed |=> !alert_n);

  a_r8_no_mask_bit6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[6]);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((fault & $past(set_vec)) == $past(set_vec)));

  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all && !en_fall |=> ((fault & ~$past(set_vec) & ~$past(status)) == 8'h00));

  a_r7_enable_fall_marks: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> fault[4]);
endmodule

bind fault_alert_regs fault_alert_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alert_n(alert_n), .ara_served(ara_served),
  .dev_addressed(dev_addressed), .new_masked(new_masked), .mask(mask),
  .fault(fault), .status(status), .set_vec(set_vec), .clr_all(clr_all),
  .en_fall(en_fall)
);

// File: tb/fault_alert_regs_bench.sv
`timescale 1ns/1ps
module fault_alert_regs_bench;
  localparam int SW = 12;
  localparam int LIM = 8;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [3:0] cond_live, cond_set;
  logic [SW-1:0] sense_code;
  logic gate_on, gp_in_high, ext_fault_low, on_pin, en_pin, uvlo;
  logic fault_wr, mask_wr, ctrl_wr, ara_served, dev_addressed;
  logic [7:0] fault_wdata, mask_wdata, ctrl_wdata;
  logic [7:0] status, fault, mask, ctrl;
  logic alert_n;

  int checks = 0;
  int errors = 0;

  fault_alert_regs u_fault_alert_regs (
    .clk(clk), .rst_n(rst_n), .cond_live(cond_live), .cond_set(cond_set),
    .sense_code(sense_code), .gate_on(gate_on), .gp_in_high(gp_in_high),
    .ext_fault_low(ext_fault_low), .on_pin(on_pin), .en_pin(en_pin),
    .uvlo(uvlo), .fault_wr(fault_wr), .fault_wdata(fault_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .ara_served(ara_served),
    .dev_addressed(dev_addressed), .status(status), .fault(fault),
    .mask(mask), .ctrl(ctrl), .alert_n(alert_n)
  );

  // behavioural reference model
  bit [7:0] m_status, m_fault, m_mask, m_ctrl, m_prev;
  bit m_pend, m_on, m_en;

  always @(posedge clk) begin
    bit [7:0] ns, nf, st;
    bit ef, cf, wipe, fresh, shortc;
    if (!rst_n) begin
      m_status = 0; m_fault = 0; m_mask = 0; m_ctrl = 0;
      m_prev = 0; m_pend = 0; m_on = 0; m_en = 0;
    end else begin
      shortc = (int'(sense_code) >= LIM) && !gate_on;
      ef   = m_en && !en_pin;
      cf   = ctrl_wr && m_ctrl[3] && !ctrl_wdata[3];
      wipe = (m_on && !on_pin) || cf || uvlo;
      ns = 0;
      for (int i = 0; i < 4; i++) ns[i] = cond_live[i];
      ns[5] = shortc; ns[6] = gp_in_high;
      st = 0;
      for (int i = 0; i < 4; i++) st[i] = cond_set[i];
      st[4] = ef; st[5] = shortc; st[6] = gp_in_high; st[7] = ext_fault_low;
      for (int i = 0; i < 8; i++) begin
        bit v;
        v = m_fault[i];
        if (fault_wr && !fault_wdata[i]) v = 0;
        if (wipe) v = 0;
        if (ef && i != 4) v = 0;
        if (m_status[i]) v = m_fault[i];
        nf[i] = v | st[i];
      end
      fresh = 0;
      for (int i = 0; i < 8; i++)
        if (m_fault[i] && !m_prev[i] && m_mask[i]) fresh = 1;
      if (fresh) m_pend = 1;
      else if (ara_served || dev_addressed) m_pend = 0;
      m_prev = m_fault;
      m_fault = nf;
      m_status = ns;
      if (mask_wr) begin m_mask = mask_wdata; m_mask[6] = 0; end
      if (ctrl_wr) m_ctrl = ctrl_wdata;
      m_on = on_pin; m_en = en_pin;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 status vs model", status, m_status);
    chk("R3 fault vs model", fault, m_fault);
    chk("R8 mask vs model", mask, m_mask);
    chk("R12 ctrl vs model", ctrl, m_ctrl);
    chk("R9 alert_n vs model", alert_n, !m_pend);
  end

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic pulse_set(input logic [3:0] v); cond_set = v; cyc(); cond_set = 0; endtask
  task automatic wr_fault(input logic [7:0] v);
    fault_wr = 1; fault_wdata = v; cyc(); fault_wr = 0;
  endtask
  task automatic ara(); ara_served = 1; cyc(); ara_served = 0; endtask

  initial begin
    #(10 * 50000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cond_live = 0; cond_set = 0; sense_code = 0; gate_on = 0;
    gp_in_high = 0; ext_fault_low = 0; on_pin = 0; en_pin = 0; uvlo = 0;
    fault_wr = 0; mask_wr = 0; ctrl_wr = 0; ara_served = 0; dev_addressed = 0;
    fault_wdata = 0; mask_wdata = 0; ctrl_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 fault reset", fault, 0);
    chk("R1 mask reset", mask, 0);
    chk("R1 status reset", status, 0);
    chk("R1 ctrl reset", ctrl, 0);
    chk("R1 alert_n reset", alert_n, 1);

    mask_wr = 1; mask_wdata = 8'hFF; cyc(); mask_wr = 0;
    chk("R8 mask bit6 forced low", mask, 8'hBF);

    pulse_set(4'b0001);
    chk("R3 set pulse latches bit0", fault, 8'h01);
    chk("R9 alert not yet low", alert_n, 1);
    cyc();
    chk("R9 alert low after masked rise", alert_n, 0);
    ara();
    chk("R10 release by ARA", alert_n, 1);
    pulse_set(4'b0001); cyc();
    chk("R11 continuing fault no re-alert", alert_n, 1);

    wr_fault(8'h00);
    chk("R4 write zero clears", fault, 8'h00);
    pulse_set(4'b0001); cyc();
    chk("R11 re-alert after clear and set", alert_n, 0);
    dev_addressed = 1; cyc(); dev_addressed = 0;
    chk("R10 release by addressing", alert_n, 1);
    pulse_set(4'b0100); cyc();
    chk("R11 different bit alerts", alert_n, 0);
    ara();

    cond_live = 4'b0010; pulse_set(4'b0010);
    chk("R2 status follows live", status, 8'h02);
    chk("R3 fault holds three bits", fault, 8'h07);
    wr_fault(8'h00);
    chk("R4 live bit not clearable", fault, 8'h02);
    cond_live = 0; cyc();
    wr_fault(8'h00);
    chk("R4 clear after condition ends", fault, 8'h00);
    ara();

    pulse_set(4'b0100);
    cond_set = 4'b0100; fault_wr = 1; fault_wdata = 8'h00; cyc();
    cond_set = 0; fault_wr = 0;
    chk("R5 set beats write clear", fault, 8'h04);
    cond_set = 4'b0100; uvlo = 1; cyc(); cond_set = 0; uvlo = 0;
    chk("R5 set beats lockout clear", fault, 8'h04);
    ara();

    ctrl_wr = 1; ctrl_wdata = 8'h08; cyc(); ctrl_wr = 0;
    chk("R12 ctrl readback", ctrl, 8'h08);
    pulse_set(4'b0001);
    ctrl_wr = 1; ctrl_wdata = 8'h00; cyc(); ctrl_wr = 0;
    chk("R6 ctrl bit3 fall clears all", fault, 8'h00);
    ara();

    on_pin = 1; cyc(); pulse_set(4'b0011);
    on_pin = 0; cyc();
    chk("R6 on_pin fall clears all", fault, 8'h00);
    pulse_set(4'b1000);
    uvlo = 1; cyc(); uvlo = 0;
    chk("R6 lockout clears all", fault, 8'h00);
    cyc();

    en_pin = 1; cyc(); pulse_set(4'b0011);
    en_pin = 0; cyc();
    chk("R7 enable fall leaves only bit4", fault, 8'h10);
    wr_fault(8'h00);
    ara();

    gp_in_high = 1; cyc();
    chk("R2 gp status bit6", status, 8'h40);
    chk("R3 gp fault bit6", fault, 8'h40);
    cyc(); cyc();
    chk("R8 bit6 never alerts", alert_n, 1);
    gp_in_high = 0; cyc(); wr_fault(8'h00);

    ext_fault_low = 1; cyc(); ext_fault_low = 0;
    chk("R3 external fault bit7", fault, 8'h80);
    chk("R2 bit7 has no status", status, 8'h00);
    cyc();
    chk("R9 bit7 masked alert", alert_n, 0);
    wr_fault(8'h00); ara();

    sense_code = SW'(LIM - 1); cyc();
    chk("R2 short below limit", status, 8'h00);
    sense_code = SW'(LIM); cyc();
    chk("R2 short at limit", status, 8'h20);
    chk("R3 short fault bit5", fault, 8'h20);
    gate_on = 1; sense_code = SW'(100); cyc();
    chk("R2 no short with gate on", status, 8'h00);
    chk("R3 short bit sticky", fault, 8'h20);
    wr_fault(8'h00); gate_on = 0; sense_code = 0; ara();

    mask_wr = 1; mask_wdata = 8'h01; cyc(); mask_wr = 0;
    ara();
    pulse_set(4'b0100); cyc(); cyc();
    chk("R9 unmasked bit no alert", alert_n, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule